// File: doc/BRIEF.md
# Lane Receive-Mode Override Sequencer

This block runs the receive-mode override of one lane of a four-lane combo PHY once a link reset has finished. It reaches the PHY only through a single-outstanding register access port: it raises a request with an address, a write flag and write data, and it holds them until the PHY side acknowledges. On a read, the acknowledge carries the data. Each lane has its own status register and its own override register. Both addresses are a base plus the lane number times a fixed stride.

An override command works in two phases. First it polls the lane status until the half-rate bit drops, giving up after a parameterised number of reads. Then it reads the status once more, keeps that value in a local shadow register, and writes the shadow to the override register five times. Before each write it changes one field of the shadow: override enable off, override enable on, a new DPLL mode, DPLL reset on, and DPLL reset off. A separate disable command reads the status and writes it back with the override enable cleared. When the port has no PHY attached, both commands finish without touching the PHY. A one-cycle done pulse marks the end of every command. A sticky flag reports a poll phase that ran out while the lane was still at half rate.

Top module: `lane_rx_override_seq`

## Requirements
- R1: During and after reset, regReq, busy, done and pollTimeout are all 0.
- R2: The status register address is 0x2002 + lane*0x100 and the override register address is 0x2005 + lane*0x100. The lane comes from laneSel, sampled in the cycle the command is accepted.
- R3: While regReq is high and regAck is low, regReq stays high and regAddr, regWe and regWdata hold their values in the next cycle.
- R4: An override command reads the status register repeatedly while bit 0 (half rate) of the returned data is 1. It stops after the first read that returns 0, or after MAX_POLLS reads, whichever comes first.
- R5: pollTimeout goes to 1 when the last poll read still returns bit 0 = 1. It keeps its value until the next accepted command, which clears it.
- R6: After polling, an override command makes one more status read returning V. It then makes exactly five writes to the override register, in this order: W1 = V with bit 14 cleared; W2 = W1 with bit 14 set; W3 = W2 with bits 10:8 replaced by MODE_VALUE (default 3); W4 = W3 with bit 11 set; W5 = W4 with bit 11 cleared.
- R7: A disable command does not poll. It makes one status read returning V and one write of V with bit 14 cleared to the override register.
- R8: When phyPresent is 0 at acceptance, a command makes no register access, and done pulses in the cycle after acceptance.
- R9: done is high for exactly one cycle, in the cycle after the acknowledge of the last access. busy is high from the cycle after acceptance until that cycle and is low while done is high.
- R10: Commands that arrive while busy is high are ignored. When startOverride and startDisable are high in the same idle cycle, the override runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startOverride | input | 1 | Start the override command (pulse) |
| startDisable | input | 1 | Start the disable command (pulse) |
| laneSel | input | LANE_W | Lane index for the command |
| phyPresent | input | 1 | The port has a PHY attached |
| regReq | output | 1 | Register access request |
| regWe | output | 1 | 1 = write, 0 = read |
| regAddr | output | ADDR_W | Register address |
| regWdata | output | DATA_W | Write data |
| regAck | input | 1 | Access acknowledge, one cycle |
| regRdata | input | DATA_W | Read data, valid with regAck |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command finished (pulse) |
| pollTimeout | output | 1 | Last poll phase ended with half rate still set |

## Verification
A corrupted shadow register shows up in the write data of the very next override write. Each of the five writes therefore gets its own expected value, so a slip in any one field step is caught on that access. A poll counter that is off by one changes the number of status reads and the timeout flag, and both are checked when the command ends. A state machine that skips or repeats a step changes the order or the count of the logged accesses, or moves the done pulse. Commands issued mid-sequence would disturb the access log at once, so that log is compared access by access against the expected one.

// File: rtl/lro_pkg.sv
package lro_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_POLL,
    S_READ,
    S_WCLR,
    S_WSET,
    S_WMODE,
    S_WRSTH,
    S_WRSTL,
    S_DONE
  } lroState_t;

  typedef struct packed {
    logic latchLane;
    logic clrTimeout;
    logic setTimeout;
    logic pollClr;
    logic pollInc;
    logic loadRead;
    logic setOvr;
    logic putMode;
    logic setRst;
    logic clrRst;
  } lroStrobes_t;

endpackage

// File: rtl/lro_datapath.sv
module lro_datapath
  import lro_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LANE_W = 2,
  parameter logic [ADDR_W-1:0] STATUS_BASE = 16'h2002,
  parameter logic [ADDR_W-1:0] OVR_BASE = 16'h2005,
  parameter logic [ADDR_W-1:0] LANE_STRIDE = 16'h0100,
  parameter int OVR_BIT = 14,
  parameter int RST_BIT = 11,
  parameter int MODE_LSB = 8,
  parameter int MODE_W = 3,
  parameter int MODE_VALUE = 3,
  parameter int MAX_POLLS = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  lroStrobes_t       strb,
  input  logic [LANE_W-1:0] laneIn,
  input  logic [DATA_W-1:0] rdData,
  input  logic              wrSel,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  output logic              halfRate,
  output logic              pollLast,
  output logic              pollTimeout
);

  localparam int CNT_W = $clog2(MAX_POLLS + 1);
  localparam logic [DATA_W-1:0] OVR_MASK = DATA_W'(1) << OVR_BIT;
  localparam logic [DATA_W-1:0] RST_MASK = DATA_W'(1) << RST_BIT;
  localparam logic [DATA_W-1:0] MODE_MASK = ((DATA_W'(1) << MODE_W) - DATA_W'(1)) << MODE_LSB;
  localparam logic [DATA_W-1:0] MODE_FIELD = (DATA_W'(MODE_VALUE) << MODE_LSB) & MODE_MASK;

  logic [LANE_W-1:0] laneReg;
  logic [DATA_W-1:0] shadow;
  logic [CNT_W-1:0]  pollCnt;
  logic              timeoutReg;
  logic [ADDR_W-1:0] laneOff;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      laneReg <= '0;
    end else if (strb.latchLane) begin
      laneReg <= laneIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadow <= '0;
    end else if (strb.loadRead) begin
      shadow <= rdData & ~OVR_MASK;
    end else if (strb.setOvr) begin
      shadow <= shadow | OVR_MASK;
    end else if (strb.putMode) begin
      shadow <= (shadow & ~MODE_MASK) | MODE_FIELD;
    end else if (strb.setRst) begin
      shadow <= shadow | RST_MASK;
    end else if (strb.clrRst) begin
      shadow <= shadow & ~RST_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pollCnt <= '0;
    end else if (strb.pollClr) begin
      pollCnt <= '0;
    end else if (strb.pollInc) begin
      pollCnt <= pollCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timeoutReg <= 1'b0;
    end else if (strb.clrTimeout) begin
      timeoutReg <= 1'b0;
    end else if (strb.setTimeout) begin
      timeoutReg <= 1'b1;
    end
  end

  always_comb begin
    laneOff  = ADDR_W'(laneReg) * LANE_STRIDE;
    regAddr  = (wrSel ? OVR_BASE : STATUS_BASE) + laneOff;
    regWdata = shadow;
    halfRate = rdData[0];
    pollLast = (pollCnt == CNT_W'(MAX_POLLS - 1));
    pollTimeout = timeoutReg;
  end

endmodule

// File: rtl/lro_ctrl.sv
module lro_ctrl
  import lro_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startOverride,
  input  logic        startDisable,
  input  logic        phyPresent,
  input  logic        regAck,
  input  logic        halfRate,
  input  logic        pollLast,
  output lroStrobes_t strb,
  output logic        regReq,
  output logic        regWe,
  output logic        busy,
  output logic        done
);

  lroState_t state, nextState;
  logic      isDisable, nextIsDisable;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      isDisable <= 1'b0;
    end else begin
      state     <= nextState;
      isDisable <= nextIsDisable;
    end
  end

  always_comb begin
    nextState     = state;
    nextIsDisable = isDisable;
    strb          = '0;
    unique case (state)
      S_IDLE: begin
        if (startOverride || startDisable) begin
          strb.latchLane = 1'b1;
          strb.clrTimeout = 1'b1;
          strb.pollClr   = 1'b1;
          nextIsDisable  = !startOverride;
          if (!phyPresent) nextState = S_DONE;
          else if (startOverride) nextState = S_POLL;
          else nextState = S_READ;
        end
      end
      S_POLL: begin
        if (regAck) begin
          if (halfRate && !pollLast) begin
            strb.pollInc = 1'b1;
          end else begin
            strb.setTimeout = halfRate;
            nextState = S_READ;
          end
        end
      end
      S_READ: begin
        if (regAck) begin
          strb.loadRead = 1'b1;
          nextState = S_WCLR;
        end
      end
      S_WCLR: begin
        if (regAck) begin
          if (isDisable) begin
            nextState = S_DONE;
          end else begin
            strb.setOvr = 1'b1;
            nextState = S_WSET;
          end
        end
      end
      S_WSET: begin
        if (regAck) begin
          strb.putMode = 1'b1;
          nextState = S_WMODE;
        end
      end
      S_WMODE: begin
        if (regAck) begin
          strb.setRst = 1'b1;
          nextState = S_WRSTH;
        end
      end
      S_WRSTH: begin
        if (regAck) begin
          strb.clrRst = 1'b1;
          nextState = S_WRSTL;
        end
      end
      S_WRSTL: begin
        if (regAck) nextState = S_DONE;
      end
      S_DONE: nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_comb begin
    regReq = (state != S_IDLE) && (state != S_DONE);
    regWe  = (state == S_WCLR) || (state == S_WSET) || (state == S_WMODE) ||
             (state == S_WRSTH) || (state == S_WRSTL);
    busy   = regReq;
    done   = (state == S_DONE);
  end

endmodule

// File: rtl/lane_rx_override_seq.sv
module lane_rx_override_seq
  import lro_pkg::*;
#(
  parameter int LANES = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int MODE_VALUE = 3,
  parameter int MAX_POLLS = 1000,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startOverride,
  input  logic              startDisable,
  input  logic [LANE_W-1:0] laneSel,
  input  logic              phyPresent,
  output logic              regReq,
  output logic              regWe,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  input  logic              regAck,
  input  logic [DATA_W-1:0] regRdata,
  output logic              busy,
  output logic              done,
  output logic              pollTimeout
);

  lroStrobes_t strb;
  logic        halfRate;
  logic        pollLast;

  lro_ctrl ctrl_i (
    .clk(clk),
    .rstN(rstN),
    .startOverride(startOverride),
    .startDisable(startDisable),
    .phyPresent(phyPresent),
    .regAck(regAck),
    .halfRate(halfRate),
    .pollLast(pollLast),
    .strb(strb),
    .regReq(regReq),
    .regWe(regWe),
    .busy(busy),
    .done(done)
  );

  lro_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LANE_W(LANE_W),
    .MODE_VALUE(MODE_VALUE),
    .MAX_POLLS(MAX_POLLS)
  ) dp_i (
    .clk(clk),
    .rstN(rstN),
    .strb(strb),
    .laneIn(laneSel),
    .rdData(regRdata),
    .wrSel(regWe),
    .regAddr(regAddr),
    .regWdata(regWdata),
    .halfRate(halfRate),
    .pollLast(pollLast),
    .pollTimeout(pollTimeout)
  );

endmodule

// File: rtl/lro_checker.sv
module lro_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] STATUS_BASE = 16'h2002,
  parameter logic [ADDR_W-1:0] OVR_BASE = 16'h2005,
  parameter logic [ADDR_W-1:0] LANE_STRIDE = 16'h0100
) (
  input logic              clk,
  input logic              rstN,
  input logic              startOverride,
  input logic              startDisable,
  input logic              regReq,
  input logic              regWe,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWdata,
  input logic              regAck,
  input logic              busy,
  input logic              done,
  input logic              pollTimeout
);

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    regReq && !regAck |=> regReq && $stable(regAddr) && $stable(regWe) && $stable(regWdata));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy && !regReq);

  p_timeout_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pollTimeout) |-> busy);

  p_timeout_fall_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pollTimeout) |-> $past(startOverride || startDisable));

  p_write_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    regReq && regWe |-> ((regAddr - OVR_BASE) & (LANE_STRIDE - ADDR_W'(1))) == '0);

  p_read_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    regReq && !regWe |-> ((regAddr - STATUS_BASE) & (LANE_STRIDE - ADDR_W'(1))) == '0);

  p_reset_idle_r1: assert property (@(posedge clk)
    !rstN |=> !regReq && !busy && !done && !pollTimeout);

endmodule

bind lane_rx_override_seq lro_checker #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) chk_i (
  .clk(clk),
  .rstN(rstN),
  .startOverride(startOverride),
  .startDisable(startDisable),
  .regReq(regReq),
  .regWe(regWe),
  .regAddr(regAddr),
  .regWdata(regWdata),
  .regAck(regAck),
  .busy(busy),
  .done(done),
  .pollTimeout(pollTimeout)
);

// File: tb/lane_rx_override_seq_tb_top.sv
module lane_rx_override_seq_tb_top;

  localparam int MAXP  = 6;
  localparam int MODEV = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startOverride = 1'b0;
  logic        startDisable = 1'b0;
  logic [1:0]  laneSel = '0;
  logic        phyPresent = 1'b1;
  logic        regReq;
  logic        regWe;
  logic [15:0] regAddr;
  logic [15:0] regWdata;
  logic        regAck = 1'b0;
  logic [15:0] regRdata = '0;
  logic        busy;
  logic        done;
  logic        pollTimeout;

  int checks = 0;
  int failures = 0;

  logic [15:0] logAddr [64];
  logic        logWe   [64];
  logic [15:0] logData [64];
  int          logCount = 0;

  logic [15:0] expAddr [64];
  logic        expWe   [64];
  logic [15:0] expData [64];
  int          expCount = 0;

  int          halfN = 0;
  logic [15:0] baseVal = '0;
  int          statusIdx = 0;
  int          waitCnt = 0;

  always #5 clk = ~clk;

  lane_rx_override_seq #(
    .MAX_POLLS(MAXP),
    .MODE_VALUE(MODEV)
  ) dut_i (
    .clk(clk),
    .rstN(rstN),
    .startOverride(startOverride),
    .startDisable(startDisable),
    .laneSel(laneSel),
    .phyPresent(phyPresent),
    .regReq(regReq),
    .regWe(regWe),
    .regAddr(regAddr),
    .regWdata(regWdata),
    .regAck(regAck),
    .regRdata(regRdata),
    .busy(busy),
    .done(done),
    .pollTimeout(pollTimeout)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // PHY register responder with a latency that varies per access
  initial begin
    forever begin
      @(negedge clk);
      if (regAck) begin
        regAck = 1'b0;
      end else if (regReq) begin
        if (waitCnt < (logCount % 3)) begin
          waitCnt++;
        end else begin
          waitCnt = 0;
          if (logCount < 64) begin
            logAddr[logCount] = regAddr;
            logWe[logCount]   = regWe;
            logData[logCount] = regWdata;
          end
          logCount++;
          if (!regWe) begin
            regRdata = baseVal | ((statusIdx < halfN) ? 16'h0001 : 16'h0000);
            statusIdx++;
          end else begin
            regRdata = 16'hDEAD;
          end
          regAck = 1'b1;
        end
      end
    end
  end

  task automatic pushExp(input logic [15:0] a, input logic w, input logic [15:0] d);
    expAddr[expCount] = a;
    expWe[expCount]   = w;
    expData[expCount] = d;
    expCount++;
  endtask

  // mode: 0 override, 1 disable, 2 both starts together, 3 override with intrusion
  task automatic runCmd(input int mode, input int lane, input int n,
                        input logic [15:0] base, input bit phy);
    logic [15:0] stAddr, ovAddr, v, w;
    int pr;
    bit ovr;
    bit expTo;
    bit seen;
    ovr = (mode != 1);
    stAddr = 16'h2002 + 16'(lane) * 16'h0100;
    ovAddr = 16'h2005 + 16'(lane) * 16'h0100;
    expCount = 0;
    expTo = 1'b0;
    if (phy) begin
      if (ovr) begin
        pr = (n < MAXP) ? n + 1 : MAXP;
        expTo = (n >= MAXP);
        for (int k = 0; k < pr; k++) pushExp(stAddr, 1'b0, 16'h0);
        v = (base & 16'hFFFE) | ((pr < n) ? 16'h0001 : 16'h0000);
        pushExp(stAddr, 1'b0, 16'h0);
        w = v & ~16'h4000;                         pushExp(ovAddr, 1'b1, w);
        w = w | 16'h4000;                          pushExp(ovAddr, 1'b1, w);
        w = (w & ~16'h0700) | (16'(MODEV) << 8);   pushExp(ovAddr, 1'b1, w);
        w = w | 16'h0800;                          pushExp(ovAddr, 1'b1, w);
        w = w & ~16'h0800;                         pushExp(ovAddr, 1'b1, w);
      end else begin
        v = (base & 16'hFFFE) | ((n > 0) ? 16'h0001 : 16'h0000);
        pushExp(stAddr, 1'b0, 16'h0);
        pushExp(ovAddr, 1'b1, v & ~16'h4000);
      end
    end

    halfN = n;
    baseVal = base & 16'hFFFE;
    statusIdx = 0;
    logCount = 0;
    @(negedge clk);
    laneSel = 2'(lane);
    phyPresent = phy;
    startOverride = (mode != 1);
    startDisable = (mode == 1) || (mode == 2);
    @(negedge clk);
    startOverride = 1'b0;
    startDisable = 1'b0;
    laneSel = 2'(3 - lane);
    chk("R9", "busy after accept", int'(busy), int'(phy));
    seen = 1'b0;
    for (int c = 0; c < 400; c++) begin
      if (done) begin
        seen = 1'b1;
        break;
      end
      if (mode == 3 && c == 3) begin
        startOverride = 1'b1;
        startDisable = 1'b1;
      end else begin
        startOverride = 1'b0;
        startDisable = 1'b0;
      end
      @(negedge clk);
    end
    startOverride = 1'b0;
    startDisable = 1'b0;
    chk("R9", "done seen", int'(seen), 1);
    chk("R9", "busy low with done", int'(busy), 0);
    chk("R5", "timeout flag", int'(pollTimeout), int'(expTo));
    @(negedge clk);
    chk("R9", "done one cycle", int'(done), 0);
    if (!phy) chk("R8", "no access without phy", logCount, 0);
    else if (mode == 3) chk("R10", "access count with intrusion", logCount, expCount);
    else if (ovr) chk("R4", "access count", logCount, expCount);
    else chk("R7", "access count", logCount, expCount);
    for (int k = 0; k < expCount && k < logCount; k++) begin
      chk("R2", "address", int'(logAddr[k]), int'(expAddr[k]));
      chk(ovr ? "R6" : "R7", "write flag", int'(logWe[k]), int'(expWe[k]));
      if (expWe[k]) chk(ovr ? "R6" : "R7", "write data", int'(logData[k]), int'(expData[k]));
    end
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] b;
    repeat (4) @(negedge clk);
    chk("R1", "regReq in reset", int'(regReq), 0);
    chk("R1", "busy in reset", int'(busy), 0);
    chk("R1", "done in reset", int'(done), 0);
    chk("R1", "timeout in reset", int'(pollTimeout), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "idle after reset", int'(regReq), 0);

    // sweep lanes, half-rate durations and status patterns
    for (int lane = 0; lane < 4; lane++) begin
      for (int ni = 0; ni < 6; ni++) begin
        int n;
        n = (ni == 0) ? 0 : (ni == 1) ? 1 : (ni == 2) ? 3 :
            (ni == 3) ? MAXP - 1 : (ni == 4) ? MAXP : MAXP + 3;
        b = 16'hA5F0 ^ (16'(lane) * 16'h1357) ^ (16'(ni) * 16'h4921);
        runCmd(0, lane, n, b, 1'b1);
        if (n >= MAXP) begin
          repeat (4) @(negedge clk);
          chk("R5", "timeout held", int'(pollTimeout), 1);
          runCmd(1, lane, 0, ~b, 1'b1);
          chk("R5", "timeout cleared by next command", int'(pollTimeout), 0);
        end
      end
      runCmd(1, lane, 0, 16'h7FFE ^ 16'(lane), 1'b1);
      runCmd(1, lane, 2, 16'h4F00 | 16'(lane << 4), 1'b1);
      runCmd(0, lane, 2, 16'hFFFF, 1'b0);
      runCmd(1, lane, 2, 16'hFFFF, 1'b0);
    end

    // R10: mid-sequence commands ignored; both starts at once pick the override
    runCmd(3, 1, 2, 16'h3C3C, 1'b1);
    runCmd(2, 2, 1, 16'hC3C2, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule